// File: doc/BRIEF.md
# Truncating Float-to-Int32 Converter

This block turns an unpacked floating-point operand into a signed 32-bit integer. The operand arrives split into a class code, a sign bit, a two's-complement unbiased exponent and a mantissa whose most significant bit is the explicit leading one. That bit carries weight 2^exponent. The integer part of the magnitude is found by a right shift. Every bit shifted out is folded into a sticky bit. The conversion always discards the fraction, so it rounds toward zero whatever rounding mode the rest of the datapath uses.

Values that cannot be represented saturate. The limit depends on the sign: a magnitude of 2^31 is valid only when the value is negative. When an overflow occurs, the invalid flag is raised in place of inexact. All of this logic is combinational. A single register stage holds the result and the two flags, and a valid bit travels alongside them.

Top module: `fp_to_int_trunc`

## Requirements
- R1: Class code 0 is zero. A zero-class operand produces result 0, with both inexact and invalid clear, whatever the sign, exponent and mantissa are.
- R2: Class codes 2 (infinity), 3 (quiet NaN) and 4 (signalling NaN) count as overflow, and so do the unused codes 5 to 7.
- R3: A number-class operand (code 1) whose exponent is 32 or more overflows, whatever its mantissa.
- R4: For a number-class operand that does not overflow, the result is the integer part of the magnitude. The fraction is dropped (toward zero). The result is negated in two's complement when the sign is 1.
- R5: For a number-class operand that does not overflow, inexact is set exactly when a nonzero bit lies below the binary point. A negative exponent therefore gives result 0 with inexact set.
- R6: The integer magnitude overflows when it is at least 2^31 plus the sign bit. A magnitude of exactly 2^31 with sign 1 gives 0x80000000 with no flag set; with sign 0 it overflows.
- R7: On any overflow, invalid is 1, inexact is 0, and the result is 0x7FFFFFFF for sign 0 or 0x80000000 for sign 1.
- R8: During reset, out_valid, out_result and both flags are 0. After reset, out_valid is 1 in exactly the cycle after a cycle in which in_valid is 1. The result and flags for that operand appear together with it.
- R9: While in_valid is 0, out_result and both flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand valid this cycle |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EXP_W (16) | Unbiased exponent, two's complement |
| in_mant | input | MANT_W (66) | Mantissa; MSB is the leading one with weight 2^exponent |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | INT_W (32) | Signed integer result |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Operand out of range or not a number |

## Verification
The bench sweeps exponents from well below zero to past 32, for both signs and for several mantissa shapes. The shapes are the leading one alone, all ones, random bits, and exact integers. At exponent 31 the leading-one-alone shape lands on the 2^31 boundary. A threshold that ignored the sign would either reject 0x80000000 for negative values or accept it for positive ones. A shifter that failed to clamp or collect the bits it drops would give garbage or miss inexact for negative exponents. A design that left inexact standing next to invalid on overflow, or that saturated infinities and NaNs with the wrong sign, would show up in the flag and result compares. The non-number class codes are also driven with random payloads.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
   typedef enum logic [2:0] {
      FC_ZERO = 3'd0,
      FC_NUM  = 3'd1,
      FC_INF  = 3'd2,
      FC_QNAN = 3'd3,
      FC_SNAN = 3'd4
   } fcls_e;
endpackage

// File: rtl/f2i_sticky_shr.sv
// Right shifter that also reports whether any nonzero bit fell off the end.
module f2i_sticky_shr #(
   parameter int DATA_W = 66,
   parameter int SH_W   = 7,
   parameter bit STAGED = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   sh,
   output logic [DATA_W-1:0] dout,
   output logic              sticky
);
   generate
      if (STAGED) begin : g_log
         // logarithmic stages, sticky accumulated per stage
         logic [DATA_W-1:0] lvl [0:SH_W];
         logic              stk [0:SH_W];
         assign lvl[0] = din;
         assign stk[0] = 1'b0;
         for (genvar k = 0; k < SH_W; k++) begin : g_st
            localparam int AMT = 1 << k;
            if (AMT >= DATA_W) begin : g_all
               assign lvl[k+1] = sh[k] ? '0 : lvl[k];
               assign stk[k+1] = stk[k] | (sh[k] & (|lvl[k]));
            end else begin : g_part
               assign lvl[k+1] = sh[k] ? (lvl[k] >> AMT) : lvl[k];
               assign stk[k+1] = stk[k] | (sh[k] & (|lvl[k][AMT-1:0]));
            end
         end
         assign dout   = lvl[SH_W];
         assign sticky = stk[SH_W];
      end else begin : g_mask
         // single shift plus a mask of the bits that are dropped
         logic [DATA_W-1:0] lost_mask;
         assign dout      = din >> sh;
         assign lost_mask = ~({DATA_W{1'b1}} << sh);
         assign sticky    = |(din & lost_mask);
      end
   endgenerate
endmodule

// File: rtl/f2i_pack.sv
// Classification, range check, saturation and sign application.
module f2i_pack
   import f2i_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  logic [2:0]       cls,
   input  logic             sign,
   input  logic             exp_big,
   input  logic [INT_W-1:0] mag,
   input  logic             upper_nz,
   input  logic             sticky,
   output logic [INT_W-1:0] result,
   output logic             inexact,
   output logic             invalid
);
   localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};
   localparam logic [INT_W:0]   HALF    = {2'b01, {(INT_W-1){1'b0}}};

   logic is_zero, is_num, mag_ov, ovf;
   logic [INT_W:0] limit;

   assign is_zero = (cls == FC_ZERO);
   assign is_num  = (cls == FC_NUM);
   // negative values may reach exactly 2^(INT_W-1)
   assign limit   = HALF + {{INT_W{1'b0}}, sign};
   assign mag_ov  = upper_nz || ({1'b0, mag} >= limit);
   assign ovf     = !is_zero && (!is_num || exp_big || mag_ov);

   always_comb begin
      if (is_zero)     result = '0;
      else if (ovf)    result = sign ? NEG_SAT : POS_SAT;
      else if (sign)   result = -mag;
      else             result = mag;
   end

   assign inexact = is_num && !ovf && sticky;
   assign invalid = ovf;
endmodule

// File: rtl/f2i_out_reg.sv
module f2i_out_reg #(
   parameter int INT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [INT_W-1:0] d_result,
   input  logic             d_inexact,
   input  logic             d_invalid,
   output logic             out_valid,
   output logic [INT_W-1:0] out_result,
   output logic             out_inexact,
   output logic             out_invalid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_inexact <= 1'b0;
         out_invalid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result  <= d_result;
            out_inexact <= d_inexact;
            out_invalid <= d_invalid;
         end
      end
   end
endmodule

// File: rtl/fp_to_int_trunc.sv
module fp_to_int_trunc #(
   parameter int INT_W      = 32,
   parameter int EXP_W      = 16,
   parameter int MANT_W     = 66,
   parameter bit STAGED_SHR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_class,
   input  logic              in_sign,
   input  logic [EXP_W-1:0]  in_exp,
   input  logic [MANT_W-1:0] in_mant,
   output logic              out_valid,
   output logic [INT_W-1:0]  out_result,
   output logic              out_inexact,
   output logic              out_invalid
);
   localparam int SH_W = $clog2(MANT_W + 1);
   localparam int SX_W = EXP_W + 2;
   localparam logic signed [SX_W-1:0] SH_BASE = SX_W'(MANT_W - 1);
   localparam logic signed [SX_W-1:0] SH_CAP  = SX_W'(MANT_W);
   localparam logic [EXP_W-1:0]       EXP_LIM = EXP_W'(INT_W);
   localparam logic [SH_W-1:0]        SH_MAX  = SH_W'(MANT_W);

   generate
      if (MANT_W <= INT_W) begin : g_bad_mant
         $error("MANT_W must exceed INT_W");
      end
      if (INT_W < 2) begin : g_bad_int
         $error("INT_W must be at least 2");
      end
      if (SX_W <= SH_W || (1 << (EXP_W - 1)) <= INT_W) begin : g_bad_exp
         $error("EXP_W too narrow for the mantissa and integer widths");
      end
   endgenerate

   logic signed [SX_W-1:0] exp_sx, sh_sx;
   logic [SH_W-1:0]        sh_amt;
   logic                   exp_big;
   logic [MANT_W-1:0]      shifted;
   logic                   sticky;
   logic [INT_W-1:0]       c_result;
   logic                   c_inexact, c_invalid;

   assign exp_sx  = {{2{in_exp[EXP_W-1]}}, in_exp};
   assign sh_sx   = SH_BASE - exp_sx;
   assign exp_big = !in_exp[EXP_W-1] && (in_exp >= EXP_LIM);

   // clamp: shifting by the full width already drops every bit
   always_comb begin
      if (sh_sx[SX_W-1])       sh_amt = '0;
      else if (sh_sx > SH_CAP) sh_amt = SH_MAX;
      else                     sh_amt = sh_sx[SH_W-1:0];
   end

   f2i_sticky_shr #(
      .DATA_W (MANT_W),
      .SH_W   (SH_W),
      .STAGED (STAGED_SHR)
   ) u_shr (
      .din    (in_mant),
      .sh     (sh_amt),
      .dout   (shifted),
      .sticky (sticky)
   );

   f2i_pack #(
      .INT_W (INT_W)
   ) u_pack (
      .cls      (in_class),
      .sign     (in_sign),
      .exp_big  (exp_big),
      .mag      (shifted[INT_W-1:0]),
      .upper_nz (|shifted[MANT_W-1:INT_W]),
      .sticky   (sticky),
      .result   (c_result),
      .inexact  (c_inexact),
      .invalid  (c_invalid)
   );

   f2i_out_reg #(
      .INT_W (INT_W)
   ) u_oreg (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .d_result    (c_result),
      .d_inexact   (c_inexact),
      .d_invalid   (c_invalid),
      .out_valid   (out_valid),
      .out_result  (out_result),
      .out_inexact (out_inexact),
      .out_invalid (out_invalid)
   );
endmodule

// File: rtl/f2i_chk.sv
module f2i_chk
   import f2i_pkg::*;
#(
   parameter int INT_W = 32,
   parameter int EXP_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [2:0]       in_class,
   input logic             in_sign,
   input logic [EXP_W-1:0] in_exp,
   input logic             out_valid,
   input logic [INT_W-1:0] out_result,
   input logic             out_inexact,
   input logic             out_invalid
);
   localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};
   localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

   // R8
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R8
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R1
   zero_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == FC_ZERO) |=>
         (out_result == '0 && !out_inexact && !out_invalid));
   // R2
   nonnum_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class != FC_ZERO && in_class != FC_NUM) |=>
         (out_invalid && out_result == ($past(in_sign) ? NEG_SAT : POS_SAT)));
   // R3
   exp_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == FC_NUM && !in_exp[EXP_W-1] && in_exp >= EXP_LIM)
         |=> out_invalid);
   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_inexact && out_invalid));
   // R7
   sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid) |-> (out_result == POS_SAT || out_result == NEG_SAT));
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_result) && $stable(out_inexact) && $stable(out_invalid)));
endmodule

bind fp_to_int_trunc f2i_chk #(
   .INT_W (INT_W),
   .EXP_W (EXP_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_class    (in_class),
   .in_sign     (in_sign),
   .in_exp      (in_exp),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_inexact (out_inexact),
   .out_invalid (out_invalid)
);

// File: tb/fp_to_int_trunc_tb.sv
`timescale 1ns/1ps
module fp_to_int_trunc_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_class = '0;
   logic        in_sign = 1'b0;
   logic [15:0] in_exp = '0;
   logic [65:0] in_mant = '0;
   logic        out_valid;
   logic [31:0] out_result;
   logic        out_inexact, out_invalid;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;
   logic [63:0] rs = 64'h9E3779B97F4A7C15;

   always #4 clk = ~clk;

   fp_to_int_trunc u_dut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
      .in_class (in_class), .in_sign (in_sign), .in_exp (in_exp),
      .in_mant (in_mant), .out_valid (out_valid), .out_result (out_result),
      .out_inexact (out_inexact), .out_invalid (out_invalid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      compared++;
      if (act !== expv) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [63:0] nxt(input logic [63:0] s);
      logic [63:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   // drive one operand, then check the registered outputs
   task automatic apply(input logic [2:0] c, input logic s, input int e, input logic [65:0] m);
      logic [31:0] exp_res;
      logic        exp_inx, exp_inv;
      logic [65:0] mag_w, frac;
      string       req;
      exp_inx = 1'b0;
      exp_inv = 1'b0;
      exp_res = 32'h0;
      req = "R4";
      if (c == 3'd0) begin
         req = "R1";
      end else if (c != 3'd1) begin
         req = "R2";
         exp_inv = 1'b1;
      end else if (e >= 32) begin
         req = "R3";
         exp_inv = 1'b1;
      end else begin
         if (e < 0) begin
            mag_w = '0;
            frac  = m;
         end else begin
            mag_w = m >> (65 - e);
            frac  = m & ((66'b1 << (65 - e)) - 66'b1);
         end
         if (mag_w >= 66'h80000000 + {65'b0, s}) begin
            req = "R6";
            exp_inv = 1'b1;
         end else begin
            exp_res = s ? (32'h0 - mag_w[31:0]) : mag_w[31:0];
            exp_inx = (frac != '0);
         end
      end
      if (exp_inv) exp_res = s ? 32'h80000000 : 32'h7FFFFFFF;
      @(negedge clk);
      in_valid = 1'b1;
      in_class = c;
      in_sign  = s;
      in_exp   = 16'(e);
      in_mant  = m;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 out_valid", {31'b0, out_valid}, 32'd1);
      chk({req, " result"}, out_result, exp_res);
      chk(exp_inv ? "R7 inexact" : "R5 inexact", {31'b0, out_inexact}, {31'b0, exp_inx});
      chk(exp_inv ? "R7 invalid" : "R4 invalid", {31'b0, out_invalid}, {31'b0, exp_inv});
   endtask

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      chk("R8 reset valid", {31'b0, out_valid}, 32'd0);
      chk("R8 reset result", out_result, 32'h0);
      chk("R8 reset flags", {30'b0, out_inexact, out_invalid}, 32'd0);
      rst_n = 1'b1;

      // R6 boundary: magnitude exactly 2^31
      apply(3'd1, 1'b1, 31, {1'b1, 65'b0});   // R6 -> 0x80000000, no flags
      apply(3'd1, 1'b0, 31, {1'b1, 65'b0});   // R6 -> positive overflow
      apply(3'd1, 1'b0, 30, {66{1'b1}});      // R5: 0x7FFFFFFF inexact
      apply(3'd1, 1'b1, -1, {1'b1, 65'b0});   // R5: 0.5 -> 0 inexact
      apply(3'd1, 1'b0, 32, {1'b1, 65'b0});   // R3

      // R9: outputs hold while idle
      @(negedge clk);
      chk("R9 hold result", out_result, 32'h7FFFFFFF);
      chk("R9 hold flags", {30'b0, out_inexact, out_invalid}, 32'd1);
      chk("R8 idle valid", {31'b0, out_valid}, 32'd0);

      // sweep exponents, signs and mantissa shapes
      for (int e = -70; e <= 40; e++) begin
         for (int sg = 0; sg < 2; sg++) begin
            for (int p = 0; p < 4; p++) begin
               logic [65:0] m;
               rs = nxt(rs);
               case (p)
                  0: m = {1'b1, 65'b0};
                  1: m = {66{1'b1}};
                  2: m = {1'b1, rs, rs[5]};
                  default: m = {1'b1, rs[30:0], 34'b0};
               endcase
               apply(3'd1, sg[0], e, m);
            end
         end
      end

      // R1, R2: every non-number class with random payloads
      for (int c = 0; c < 8; c++) begin
         if (c == 1) continue;
         for (int sg = 0; sg < 2; sg++) begin
            rs = nxt(rs);
            apply(3'(c), sg[0], int'($signed(rs[15:0])), {1'b1, rs, rs[1]});
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule